// File: doc/BRIEF.md
# Load/store-multiple transfer sequencer

This block steps a processor through a block register transfer, either a multi-register load or a multi-register store, for a 32-bit core with sixteen registers. A single start handshake carries the 16-bit register list, the index and value of the base register, five operation flags and a variant select. The flags are pre-index, up, writeback, load and user bank. The variant select picks between the older and the newer architectural behaviour. The block then issues one word access per accepted cycle, in ascending register order, on a valid/ready memory port.

For each access it names the register being moved and which bank that register belongs to. On stores it reads that register through a combinational read port and forms the store word. On loads it writes the returned word back, with the program-counter adjustments applied. It decides whether the base register is rewritten, when, and with which value. A pipeline refill, an instruction-set state update and a restore of the saved status are requested through single-cycle strobes. The surrounding core owns the register file, memory and mode logic.

The variant select is `newer_var`: 0 selects the older rules and 1 selects the newer rules. Register index 15 is the program counter.

Top module: `lsm_sequencer`

## Requirements
- R1: With count = number of set list bits, the first address is base+4 (up, pre), base (up, post), base−4·count (down, pre) or base−4·count+4 (down, post). Registers are transferred in ascending index order, and each accepted access advances the address by 4.
- R2: `start_ready` is high only while idle, with no access and no `done`. While `mem_valid` is high and `mem_ready` is low, the address, index and data hold. `done` pulses for one cycle, in the cycle after the last accepted access, or in the cycle after the start when no access is made.
- R3: The written-back base value is base+4·count when the up flag is set and base−4·count when it is clear.
- R4: On the older variant, an empty list transfers only register 15. Its address is base+(pre?4:0) when up and base−0x40+(pre?0:4) when down. The base is rewritten with base±0x40 in the `done` cycle, whatever the writeback flag.
- R5: On the newer variant, an empty list makes no access. The base is rewritten with base±0x40 in the `done` cycle.
- R6: A store with writeback and the user-bank flag clear has a special rule when it moves the base register. On the older variant the old base is stored only if the base is the lowest-numbered listed register, and otherwise the new base is stored. On the newer variant the old base is always stored.
- R7: Storing register 15 writes its register value plus 4. A store with the user-bank flag set reads every register from the user bank (`xfer_user`=1).
- R8: A load with writeback rewrites the base in the `done` cycle if the base is not in the list. If the base is in the list, the older variant does not rewrite it. The newer variant rewrites it only when the base is the only listed register or is not the highest-numbered one.
- R9: A load into register 15 clears data bits 1:0 on the older variant. On the newer variant it clears bit 0 only and pulses `tstate_wr_en`, with `tstate_val` equal to data bit 0.
- R10: A load into register 15 pulses `pc_refill` in its access cycle. If the user-bank flag is set, it also pulses `status_restore`. Loads of other registers pulse neither.
- R11: A load with the user-bank flag set and register 15 absent from the list writes every register to the user bank (`xfer_user`=1). Otherwise loads use the current bank.
- R12: A store with writeback and a non-empty list rewrites the base exactly once, in the cycle of its first accepted access. A non-empty transfer without writeback never rewrites the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Operation request |
| start_ready | output | 1 | Idle, request accepted this cycle |
| list_in | input | 16 | Register list, bit i selects register i |
| base_idx | input | 4 | Base register index |
| base_val | input | 32 | Base register value |
| pre_idx | input | 1 | Pre-index flag |
| up_dir | input | 1 | 1 = ascending addresses |
| wback | input | 1 | Writeback flag |
| is_load | input | 1 | 1 = load, 0 = store |
| user_bank | input | 1 | User-bank flag |
| newer_var | input | 1 | 0 = older variant, 1 = newer variant |
| mem_valid | output | 1 | Access request |
| mem_ready | input | 1 | Access accepted |
| mem_write | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store word |
| mem_rdata | input | 32 | Load word, valid when accepted |
| xfer_idx | output | 4 | Register index of the current access |
| xfer_user | output | 1 | Current access uses the user bank |
| reg_rd_data | input | 32 | Register value at `xfer_idx` / `xfer_user` |
| reg_wr_en | output | 1 | Register write strobe (load accepted) |
| reg_wr_data | output | 32 | Register write value |
| base_wr_en | output | 1 | Base register write strobe |
| base_wr_data | output | 32 | New base value |
| pc_refill | output | 1 | Pipeline refill request |
| tstate_wr_en | output | 1 | Instruction-set state write strobe |
| tstate_val | output | 1 | Instruction-set state value |
| status_restore | output | 1 | Copy saved status into current status |
| done | output | 1 | Operation finished |

## Verification
A pending-list or address register that goes wrong shows up at the ports on the next accepted access. The affected access carries a wrong `mem_addr` or `xfer_idx`, or the operation ends with the wrong number of accesses and a misplaced `done` pulse. A wrong latched base decision surfaces later: a missing, extra or mistimed `base_wr_en`, or a wrong stored word on the conflicting access. A store shows this at its first access and a load shows it at `done`. Bank and program-counter errors are visible in the same cycle as the access, on `xfer_user`, `reg_wr_data` and the refill and status strobes.

// File: rtl/lsm_pkg.sv
// Package lsm_pkg: shared constants for the load/store-multiple sequencer.
// Assumes a word-addressed transfer of four bytes per register.
package lsm_pkg;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } lsm_state_e;
endpackage

// File: rtl/lsm_popcount.sv
// lsm_popcount: counts the set bits of a vector.
// Assumes CW is wide enough to hold W.
module lsm_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Sum the bits one by one.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowest_pick.sv
// lsm_lowest_pick: priority encoder returning the lowest set bit index.
// Assumes idx is meaningless when any is low.
module lsm_lowest_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_load_fmt.sv
// lsm_load_fmt: shapes a loaded word for the register file and raises the
// program-counter side strobes. Assumes the caller gates the strobes with
// an accepted load access.
module lsm_load_fmt #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rdata,
    input  logic            newer,
    input  logic            is_pc,
    input  logic            user,
    output logic [XLEN-1:0] wr_data,
    output logic            tstate_en,
    output logic            tstate_v,
    output logic            refill,
    output logic            restore
);
    localparam logic [XLEN-1:0] MASK_OLD = XLEN'(3);
    localparam logic [XLEN-1:0] MASK_NEW = XLEN'(1);

    // Mask the low bits on a program-counter load; pass other words through.
    always_comb begin
        if (is_pc) begin
            wr_data = newer ? (rdata & ~MASK_NEW) : (rdata & ~MASK_OLD);
        end else begin
            wr_data = rdata;
        end
        tstate_en = is_pc && newer;
        tstate_v  = rdata[0];
        refill    = is_pc;
        restore   = is_pc && user;
    end
endmodule

// File: rtl/lsm_store_pick.sv
// lsm_store_pick: forms the store word, applying the base-conflict value or
// the program-counter offset. Assumes conflict is only raised when the
// current register is the base on a writeback store.
module lsm_store_pick #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rd_data,
    input  logic            is_pc,
    input  logic            conflict,
    input  logic            keep_old,
    input  logic [XLEN-1:0] old_base,
    input  logic [XLEN-1:0] new_base,
    output logic [XLEN-1:0] wdata
);
    localparam logic [XLEN-1:0] PC_AHEAD = XLEN'(4);

    // Choose between the base values and the register read.
    always_comb begin
        if (conflict) begin
            wdata = keep_old ? old_base : new_base;
        end else begin
            wdata = rd_data + (is_pc ? PC_AHEAD : '0);
        end
    end
endmodule

// File: rtl/lsm_sequencer.sv
// lsm_sequencer: sequences a multi-register load or store, one word access
// per accepted cycle, and decides the base writeback. Assumes a register
// read port that answers combinationally for xfer_idx/xfer_user, and that
// mem_rdata is valid whenever mem_valid and mem_ready are both high.
module lsm_sequencer #(
    parameter int XLEN = 32,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_valid,
    output logic                    start_ready,
    input  logic [NREG-1:0]         list_in,
    input  logic [$clog2(NREG)-1:0] base_idx,
    input  logic [XLEN-1:0]         base_val,
    input  logic                    pre_idx,
    input  logic                    up_dir,
    input  logic                    wback,
    input  logic                    is_load,
    input  logic                    user_bank,
    input  logic                    newer_var,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_write,
    output logic [XLEN-1:0]         mem_addr,
    output logic [XLEN-1:0]         mem_wdata,
    input  logic [XLEN-1:0]         mem_rdata,
    output logic [$clog2(NREG)-1:0] xfer_idx,
    output logic                    xfer_user,
    input  logic [XLEN-1:0]         reg_rd_data,
    output logic                    reg_wr_en,
    output logic [XLEN-1:0]         reg_wr_data,
    output logic                    base_wr_en,
    output logic [XLEN-1:0]         base_wr_data,
    output logic                    pc_refill,
    output logic                    tstate_wr_en,
    output logic                    tstate_val,
    output logic                    status_restore,
    output logic                    done
);
    import lsm_pkg::*;

    localparam int IDXW = $clog2(NREG);
    localparam int CNTW = $clog2(NREG + 1);
    localparam int PC   = NREG - 1;
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    // Registered operation state.
    lsm_state_e      state_q;
    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] list_q;
    logic [IDXW-1:0] base_idx_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] old_base_q;
    logic [XLEN-1:0] new_base_q;
    logic            load_q;
    logic            user_q;
    logic            newer_q;
    logic            first_q;
    logic            wr_at_first_q;
    logic            wr_at_fin_q;

    // Start-time decode.
    logic [CNTW-1:0] cnt;
    logic            list_empty;
    logic [XLEN-1:0] span;
    logic [XLEN-1:0] first_addr;
    logic [XLEN-1:0] next_base;
    logic [NREG-1:0] eff_list;
    logic [NREG-1:0] list_shift;
    logic            base_in_list;
    logic            base_only;
    logic            base_has_higher;
    logic            fin_wr;
    logic            first_wr;
    logic            start_hs;

    // Transfer-time signals.
    logic [IDXW-1:0] cur_idx;
    logic            cur_any;
    logic            hs;
    logic [NREG-1:0] pend_next;
    logic            cur_is_pc;
    logic            conflict;
    logic            fmt_tstate_en;
    logic            fmt_refill;
    logic            fmt_restore;

    lsm_popcount #(.W(NREG), .CW(CNTW)) u_count (
        .vec (list_in),
        .cnt (cnt)
    );

    lsm_lowest_pick #(.W(NREG), .IW(IDXW)) u_pick (
        .vec (pend_q),
        .idx (cur_idx),
        .any (cur_any)
    );

    // Address span, first address, new base and effective list at start.
    always_comb begin
        list_empty = (list_in == '0);
        span       = (list_empty ? XLEN'(NREG) : XLEN'(cnt)) * STEP;
        if (up_dir) begin
            first_addr = base_val + (pre_idx ? STEP : '0);
            next_base  = base_val + span;
        end else begin
            first_addr = base_val - span + (pre_idx ? '0 : STEP);
            next_base  = base_val - span;
        end
        if (list_empty) begin
            eff_list = newer_var ? '0 : (NREG'(1) << PC);
        end else begin
            eff_list = list_in;
        end
    end

    // Base writeback decision taken once at start.
    always_comb begin
        list_shift      = list_in >> base_idx;
        base_in_list    = list_shift[0];
        base_only       = (list_in == (NREG'(1) << base_idx));
        base_has_higher = ((list_shift >> 1) != '0);
        first_wr        = !is_load && wback && !list_empty;
        if (list_empty) begin
            fin_wr = 1'b1;
        end else if (is_load && wback) begin
            if (!base_in_list) begin
                fin_wr = 1'b1;
            end else begin
                fin_wr = newer_var && (base_only || base_has_higher);
            end
        end else begin
            fin_wr = 1'b0;
        end
    end

    // Handshake and pending-list update.
    always_comb begin
        start_ready = (state_q == ST_IDLE);
        start_hs    = start_ready && start_valid;
        mem_valid   = (state_q == ST_XFER) && cur_any;
        hs          = mem_valid && mem_ready;
        pend_next   = pend_q & ~(NREG'(1) << cur_idx);
        cur_is_pc   = (cur_idx == IDXW'(PC));
        conflict    = wr_at_first_q && !user_q && (cur_idx == base_idx_q);
    end

    // Operation state machine and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            pend_q        <= '0;
            list_q        <= '0;
            base_idx_q    <= '0;
            addr_q        <= '0;
            old_base_q    <= '0;
            new_base_q    <= '0;
            load_q        <= 1'b0;
            user_q        <= 1'b0;
            newer_q       <= 1'b0;
            first_q       <= 1'b0;
            wr_at_first_q <= 1'b0;
            wr_at_fin_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_hs) begin
                        pend_q        <= eff_list;
                        list_q        <= eff_list;
                        base_idx_q    <= base_idx;
                        addr_q        <= first_addr;
                        old_base_q    <= base_val;
                        new_base_q    <= next_base;
                        load_q        <= is_load;
                        user_q        <= user_bank;
                        newer_q       <= newer_var;
                        first_q       <= 1'b1;
                        wr_at_first_q <= first_wr;
                        wr_at_fin_q   <= fin_wr;
                        state_q       <= (eff_list == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (hs) begin
                        pend_q  <= pend_next;
                        addr_q  <= addr_q + STEP;
                        first_q <= 1'b0;
                        if (pend_next == '0) begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    lsm_store_pick #(.XLEN(XLEN)) u_store (
        .rd_data  (reg_rd_data),
        .is_pc    (cur_is_pc),
        .conflict (conflict),
        .keep_old (newer_q || first_q),
        .old_base (old_base_q),
        .new_base (new_base_q),
        .wdata    (mem_wdata)
    );

    lsm_load_fmt #(.XLEN(XLEN)) u_load (
        .rdata     (mem_rdata),
        .newer     (newer_q),
        .is_pc     (cur_is_pc),
        .user      (user_q),
        .wr_data   (reg_wr_data),
        .tstate_en (fmt_tstate_en),
        .tstate_v  (tstate_val),
        .refill    (fmt_refill),
        .restore   (fmt_restore)
    );

    // Drive the access, bank, strobe and writeback outputs.
    always_comb begin
        mem_addr       = addr_q;
        mem_write      = mem_valid && !load_q;
        xfer_idx       = cur_idx;
        xfer_user      = load_q ? (user_q && !list_q[PC]) : user_q;
        reg_wr_en      = hs && load_q;
        pc_refill      = reg_wr_en && fmt_refill;
        tstate_wr_en   = reg_wr_en && fmt_tstate_en;
        status_restore = reg_wr_en && fmt_restore;
        done           = (state_q == ST_FIN);
        base_wr_data   = new_base_q;
        base_wr_en     = (done && wr_at_fin_q) || (hs && first_q && wr_at_first_q);
    end
endmodule

// File: rtl/lsm_sequencer_chk.sv
// lsm_sequencer_chk: temporal checks on the sequencer ports, bound to
// every lsm_sequencer instance. Assumes a synchronous active-low reset.
module lsm_sequencer_chk #(
    parameter int XLEN = 32,
    parameter int NREG = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_ready,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic                    mem_write,
    input logic [XLEN-1:0]         mem_addr,
    input logic [XLEN-1:0]         mem_wdata,
    input logic [$clog2(NREG)-1:0] xfer_idx,
    input logic                    reg_wr_en,
    input logic [XLEN-1:0]         reg_wr_data,
    input logic                    base_wr_en,
    input logic                    pc_refill,
    input logic                    done
);
    localparam int IDXW = $clog2(NREG);

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(xfer_idx) && $stable(mem_wdata))) // R2
        else $error("AST_HOLD_STALLED");

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + XLEN'(4)))) // R1
        else $error("AST_ADDR_STEP");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!mem_valid && !done)) // R2
        else $error("AST_IDLE_QUIET");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R2
        else $error("AST_DONE_PULSE");

    AST_BASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> !base_wr_en) // R12
        else $error("AST_BASE_SINGLE");

    AST_WR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (mem_valid && mem_ready && !mem_write)) // R11
        else $error("AST_WR_ON_LOAD");

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (xfer_idx == IDXW'(NREG - 1))) |-> (pc_refill && !reg_wr_data[0])) // R9
        else $error("AST_PC_LOAD");

    AST_NO_STRAY_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_refill |-> (reg_wr_en && (xfer_idx == IDXW'(NREG - 1)))) // R10
        else $error("AST_NO_STRAY_REFILL");
endmodule

bind lsm_sequencer lsm_sequencer_chk #(.XLEN(XLEN), .NREG(NREG)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ready (start_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .xfer_idx    (xfer_idx),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .base_wr_en  (base_wr_en),
    .pc_refill   (pc_refill),
    .done        (done)
);

// File: tb/lsm_sequencer_tb_top.sv
// lsm_sequencer_tb_top: directed bench with a behavioural register file and
// memory; each scenario task runs one operation and checks its results.
module lsm_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] list_in = '0;
    logic [3:0]  base_idx = '0;
    logic [31:0] base_val = '0;
    logic        pre_idx = 1'b0, up_dir = 1'b0, wback = 1'b0, is_load = 1'b0;
    logic        user_bank = 1'b0, newer_var = 1'b0;
    logic        mem_valid, mem_ready = 1'b0, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  xfer_idx;
    logic        xfer_user;
    logic [31:0] reg_rd_data;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic        base_wr_en;
    logic [31:0] base_wr_data;
    logic        pc_refill, tstate_wr_en, tstate_val, status_restore, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] cur_reg(input logic [3:0] i);
        return 32'h1000_0000 + 32'(i) * 32'h0101;
    endfunction
    function automatic logic [31:0] usr_reg(input logic [3:0] i);
        return 32'h7000_0000 + 32'(i) * 32'h0011;
    endfunction
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2] ^ 30'h15A5_0000, 2'b11};
    endfunction

    assign reg_rd_data = xfer_user ? usr_reg(xfer_idx) : cur_reg(xfer_idx);
    assign mem_rdata   = mem_word(mem_addr);

    lsm_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .list_in(list_in), .base_idx(base_idx), .base_val(base_val),
        .pre_idx(pre_idx), .up_dir(up_dir), .wback(wback), .is_load(is_load),
        .user_bank(user_bank), .newer_var(newer_var),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_idx(xfer_idx), .xfer_user(xfer_user), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .pc_refill(pc_refill), .tstate_wr_en(tstate_wr_en), .tstate_val(tstate_val),
        .status_restore(status_restore), .done(done)
    );

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // Runs one operation and checks every access and the base writeback.
    task automatic run_op(input string tg, input logic [15:0] lst, input logic [3:0] rn,
                          input logic [31:0] base, input logic p, input logic u,
                          input logic w, input logic l, input logic s, input logic nv,
                          input int stall);
        int cnt, n, k, last_hs, bw_n;
        logic [3:0]  ei [16];
        logic [15:0] el;
        logic [31:0] span, first, nb, ew, er, rd;
        logic emp, exp_bw, exp_at_done, bw_first, bw_done, seen_done, hsn, pc;
        logic [15:0] sh;
        cnt = 0;
        for (int i = 0; i < 16; i++) cnt += int'(lst[i]);
        emp   = (lst == 16'h0);
        span  = 32'(emp ? 16 : cnt) * 32'd4;
        first = u ? base + (p ? 32'd4 : 32'd0) : base - span + (p ? 32'd0 : 32'd4);
        nb    = u ? base + span : base - span;
        el    = emp ? (nv ? 16'h0 : 16'h8000) : lst;
        n = 0;
        for (int i = 0; i < 16; i++) if (el[i]) begin ei[n] = 4'(i); n++; end
        sh = lst >> rn;
        exp_at_done = 1'b1;
        if (emp) exp_bw = 1'b1;
        else if (!l) begin exp_bw = w; exp_at_done = 1'b0; end
        else if (!w) exp_bw = 1'b0;
        else if (!sh[0]) exp_bw = 1'b1;
        else exp_bw = nv && ((lst == (16'h1 << rn)) || ((sh >> 1) != 16'h0));

        @(negedge clk);
        chk({tg, " R2 idle ready"}, 32'(start_ready), 32'd1);
        list_in = lst; base_idx = rn; base_val = base; pre_idx = p; up_dir = u;
        wback = w; is_load = l; user_bank = s; newer_var = nv; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        k = 0; last_hs = -1; bw_n = 0; bw_first = 0; bw_done = 0; seen_done = 0;
        for (int cyc = 0; cyc < 80 && !seen_done; cyc++) begin
            mem_ready = (stall == 0) ? 1'b1 : ((cyc % stall) == (stall - 1));
            #1;
            hsn = mem_valid && mem_ready;
            if (mem_valid) begin
                if (k >= n) begin
                    chk({tg, " R1 extra access"}, 32'(k), 32'(n));
                end else begin
                    pc = (ei[k] == 4'd15);
                    chk({tg, " R1 address"}, mem_addr, first + 32'(k) * 32'd4);
                    chk({tg, " R1 index"}, 32'(xfer_idx), 32'(ei[k]));
                    chk({tg, " R2 direction"}, 32'(mem_write), 32'(!l));
                    chk({tg, " R7 R11 bank"}, 32'(xfer_user), 32'(l ? (s && !el[15]) : s));
                    if (!l) begin
                        if (s) ew = usr_reg(ei[k]) + (pc ? 32'd4 : 32'd0);
                        else if (w && !emp && ei[k] == rn) ew = (nv || k == 0) ? base : nb;
                        else ew = cur_reg(ei[k]) + (pc ? 32'd4 : 32'd0);
                        chk({tg, " R6 R7 store word"}, mem_wdata, ew);
                    end else if (hsn) begin
                        rd = mem_word(mem_addr);
                        er = pc ? (nv ? (rd & ~32'h1) : (rd & ~32'h3)) : rd;
                        chk({tg, " R11 load strobe"}, 32'(reg_wr_en), 32'd1);
                        chk({tg, " R9 load word"}, reg_wr_data, er);
                        chk({tg, " R10 refill"}, 32'(pc_refill), 32'(pc));
                        chk({tg, " R10 restore"}, 32'(status_restore), 32'(pc && s));
                        chk({tg, " R9 state strobe"}, 32'(tstate_wr_en), 32'(pc && nv));
                        if (pc && nv) chk({tg, " R9 state value"}, 32'(tstate_val), 32'(rd[0]));
                    end
                end
            end
            if (base_wr_en) begin
                bw_n++;
                if (done) bw_done = 1'b1;
                if (hsn && k == 0) bw_first = 1'b1;
                chk({tg, " R3 base value"}, base_wr_data, nb);
            end
            if (done) begin
                seen_done = 1'b1;
                chk({tg, " R2 done timing"}, 32'(cyc), 32'(last_hs + 1));
            end
            if (hsn) begin k++; last_hs = cyc; end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        chk({tg, " R2 done seen"}, 32'(seen_done), 32'd1);
        chk({tg, " R1 access count"}, 32'(k), 32'(n));
        chk({tg, " R8 R12 base write count"}, 32'(bw_n), 32'(exp_bw));
        if (exp_bw) begin
            if (exp_at_done) chk({tg, " R8 base write at done"}, 32'(bw_done), 32'd1);
            else chk({tg, " R12 base write at first access"}, 32'(bw_first), 32'd1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R2 reset ready", 32'(start_ready), 32'd1);
        chk("R2 reset no access", 32'(mem_valid), 32'd0);
        chk("R2 reset no done", 32'(done), 32'd0);
        chk("R12 reset no base write", 32'(base_wr_en), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_store_up_pre();   run_op("R1 R3 R12 store up pre", 16'h00F0, 4'd2, 32'h0000_1000, 1, 1, 1, 0, 0, 0, 0); endtask
    task automatic t_load_down_post(); run_op("R1 R2 R8 load down post stalled", 16'h0106, 4'd13, 32'h0000_2000, 0, 0, 1, 1, 0, 0, 3); endtask
    task automatic t_store_no_wb();    run_op("R12 store no writeback", 16'h0009, 4'd0, 32'h0000_4100, 0, 1, 0, 0, 0, 1, 2); endtask
    task automatic t_load_up_post();   run_op("R1 R3 load up post", 16'h0A00, 4'd5, 32'h0000_5000, 0, 1, 1, 1, 0, 1, 0); endtask
    task automatic t_store_down_pre(); run_op("R1 R3 store down pre", 16'h0C03, 4'd7, 32'h0000_6000, 1, 0, 1, 0, 0, 0, 0); endtask
    task automatic t_empty_old_load(); run_op("R4 empty older load down pre", 16'h0000, 4'd1, 32'h0000_3000, 1, 0, 0, 1, 0, 0, 0); endtask
    task automatic t_empty_old_store();run_op("R4 R7 empty older store up post", 16'h0000, 4'd3, 32'h0000_3100, 0, 1, 0, 0, 0, 0, 2); endtask
    task automatic t_empty_old_down(); run_op("R4 empty older store down post", 16'h0000, 4'd3, 32'h0000_3200, 0, 0, 1, 0, 0, 0, 0); endtask
    task automatic t_empty_newer();    run_op("R5 empty newer", 16'h0000, 4'd6, 32'h0000_3300, 1, 1, 0, 1, 0, 1, 0); endtask
    task automatic t_stm_old_first();  run_op("R6 older base first", 16'h0031, 4'd0, 32'h0000_7000, 0, 1, 1, 0, 0, 0, 0); endtask
    task automatic t_stm_old_later();  run_op("R6 older base later", 16'h0031, 4'd4, 32'h0000_7100, 0, 1, 1, 0, 0, 0, 0); endtask
    task automatic t_stm_new_later();  run_op("R6 newer base later", 16'h0031, 4'd5, 32'h0000_7200, 1, 0, 1, 0, 0, 1, 0); endtask
    task automatic t_ldm_old_in();     run_op("R8 older base in list", 16'h0012, 4'd4, 32'h0000_8000, 0, 1, 1, 1, 0, 0, 0); endtask
    task automatic t_ldm_new_low();    run_op("R8 newer base not highest", 16'h0012, 4'd1, 32'h0000_8100, 0, 1, 1, 1, 0, 1, 0); endtask
    task automatic t_ldm_new_high();   run_op("R8 newer base highest", 16'h0012, 4'd4, 32'h0000_8200, 0, 1, 1, 1, 0, 1, 0); endtask
    task automatic t_ldm_new_only();   run_op("R8 newer base only", 16'h0008, 4'd3, 32'h0000_8300, 1, 0, 1, 1, 0, 1, 0); endtask
    task automatic t_pc_load_old();    run_op("R9 R10 older pc load", 16'h8001, 4'd2, 32'h0000_9000, 1, 1, 0, 1, 0, 0, 0); endtask
    task automatic t_pc_load_new();    run_op("R9 R10 newer pc load user", 16'h8001, 4'd2, 32'h0000_9100, 0, 0, 0, 1, 1, 1, 2); endtask
    task automatic t_user_load();      run_op("R11 user load", 16'h0C00, 4'd1, 32'h0000_A000, 0, 1, 1, 1, 1, 0, 0); endtask
    task automatic t_user_store_pc();  run_op("R7 user store with pc", 16'h8004, 4'd2, 32'h0000_B000, 1, 1, 1, 0, 1, 0, 0); endtask
    task automatic t_store_pc();       run_op("R7 store pc", 16'h8000, 4'd0, 32'h0000_C000, 0, 1, 0, 0, 0, 1, 0); endtask

    initial begin
        t_reset();
        t_store_up_pre();
        t_load_down_post();
        t_store_no_wb();
        t_load_up_post();
        t_store_down_pre();
        t_empty_old_load();
        t_empty_old_store();
        t_empty_old_down();
        t_empty_newer();
        t_stm_old_first();
        t_stm_old_later();
        t_stm_new_later();
        t_ldm_old_in();
        t_ldm_new_low();
        t_ldm_new_high();
        t_ldm_new_only();
        t_pc_load_old();
        t_pc_load_new();
        t_user_load();
        t_user_store_pc();
        t_store_pc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule